// File: doc/BRIEF.md
# SPI Receive Queue with Destructive Read Port

This block sits between the shift register of an SPI engine and the host bus. Each time the serializer finishes a frame it raises a one-cycle capture strobe with the received word. The block stores that word at the tail of a small circular queue. The host empties the queue by strobing a pop read. The oldest stored word then appears on the data output in the following cycle and leaves the queue. A stored word can leave the queue only through a pop read or a flush.

The block reports four things on its outputs: how many entries are valid, the slot index that the next pop read will return, a drain request that stays high while anything is queued, and a sticky overflow flag. A configuration input sets what happens when a frame completes while the queue is full. In one setting the new frame is dropped. In the other setting it replaces the oldest stored word. A flush strobe empties the queue, returns both pointers to slot zero and clears the overflow flag.

Top module: `spi_rx_popq`

## Requirements
- R1: While reset is held and just after it, entryCount is 0, popIndex is 0, overflow is 0, drainReq is 0 and popData is 0.
- R2: A capture strobe while the queue is not full stores capData at the tail of the queue. entryCount rises by one on the next clock edge.
- R3: A pop read while the queue is not empty places the oldest stored word on popData one cycle after the strobe and removes that word. entryCount falls by one. Words come out in the order they were captured.
- R4: popIndex advances by one after every accepted pop and wraps from DEPTH-1 to 0.
- R5: A capture and an accepted pop in the same cycle leave entryCount unchanged, advance popIndex, and store the new word at the tail.
- R6: A pop read while the queue is empty changes nothing: popData keeps its previous value, and entryCount and popIndex stay the same.
- R7: With overwriteMode = 0, a capture while the queue is full and no pop is accepted drops the frame and sets overflow. The stored contents and entryCount do not change. overflow then stays set until a flush or a reset.
- R8: With overwriteMode = 1, a capture while the queue is full and no pop is accepted replaces the oldest word with the new one. entryCount stays at DEPTH, popIndex advances by one and overflow is set.
- R9: A flush strobe makes entryCount 0, popIndex 0 and overflow 0 on the next edge. A capture or pop in the same cycle is ignored.
- R10: drainReq is 1 exactly when entryCount is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capValid | input | 1 | One-cycle strobe: the shift register has completed a frame |
| capData | input | DATA_W | Completed frame from the shift register |
| popRead | input | 1 | One-cycle destructive read strobe from the host |
| flush | input | 1 | Empties the queue and clears overflow |
| overwriteMode | input | 1 | 1: a capture while full overwrites the oldest word; 0: it drops the frame |
| popData | output | DATA_W | Word returned by the most recent accepted pop |
| entryCount | output | $clog2(DEPTH+1) | Number of valid entries |
| popIndex | output | max(1,$clog2(DEPTH)) | Slot that the next pop will return |
| drainReq | output | 1 | High while the queue holds at least one entry |
| overflow | output | 1 | Sticky: a frame arrived while the queue was full |

## Verification
The assertions check the following relations on every cycle:
- entryCount never exceeds DEPTH.
- A capture without a pop raises entryCount by one.
- A flush clears the count, the pointer and the flag.
- An empty pop leaves popData and entryCount untouched.
- A capture while full always ends with overflow set.
- overflow stays set until a flush.

Some behaviour depends on what was stored earlier, and only the bench scenarios can show it. These are the words returned in capture order, the survival of the original words after a dropped frame, the replacement of the oldest word in overwrite mode, and the wrap of popIndex after many cycles around the ring.

// File: rtl/spi_rx_popq_pkg.sv
package spi_rx_popq_pkg;

  // Widest slot index the queue supports (depth up to 16 entries).
  localparam int MaxIdxW = 4;

  // Strobes sent from the control block to the storage block.
  typedef struct packed {
    logic               writeEn;
    logic [MaxIdxW-1:0] writeIdx;
    logic               readEn;
    logic [MaxIdxW-1:0] readIdx;
  } qStrobes_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import spi_rx_popq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobes_t         strobes,
  input  logic [DATA_W-1:0] capData,
  output logic [DATA_W-1:0] popData
);

  logic [DATA_W-1:0] slotMem [DEPTH];

  // One write-enabled register per slot.
  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strobes.writeEn && strobes.writeIdx == MaxIdxW'(i)) begin
        slotMem[i] <= capData;
      end
    end
  end

  // Registered read port: it updates only when a pop is accepted.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      popData <= '0;
    end else if (strobes.readEn) begin
      popData <= slotMem[strobes.readIdx[PTR_W-1:0]];
    end
  end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import spi_rx_popq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capValid,
  input  logic             popRead,
  input  logic             flush,
  input  logic             overwriteMode,
  output qStrobes_t        strobes,
  output logic [CNT_W-1:0] entryCount,
  output logic [PTR_W-1:0] popIndex,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] FullCount = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LastIdx   = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             isFull;
  logic             isEmpty;
  logic             popOk;
  logic             capAccept;
  logic             capReplace;
  logic             capDrop;

  function automatic logic [PTR_W-1:0] nextIdx(input logic [PTR_W-1:0] p);
    return (p == LastIdx) ? '0 : p + PTR_W'(1);
  endfunction

  assign isFull     = (entryCount == FullCount);
  assign isEmpty    = (entryCount == '0);
  assign popOk      = popRead && !isEmpty && !flush;
  assign capAccept  = capValid && !flush && (!isFull || popOk);
  assign capReplace = capValid && !flush && isFull && !popOk && overwriteMode;
  assign capDrop    = capValid && !flush && isFull && !popOk && !overwriteMode;

  always_comb begin
    strobes.writeEn  = capAccept || capReplace;
    strobes.writeIdx = MaxIdxW'(wrPtr);
    strobes.readEn   = popOk;
    strobes.readIdx  = MaxIdxW'(rdPtr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      entryCount <= '0;
      overflow   <= 1'b0;
    end else if (flush) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      entryCount <= '0;
      overflow   <= 1'b0;
    end else begin
      if (capAccept || capReplace) begin
        wrPtr <= nextIdx(wrPtr);
      end
      if (popOk || capReplace) begin
        rdPtr <= nextIdx(rdPtr);
      end
      if (capAccept && !popOk) begin
        entryCount <= entryCount + CNT_W'(1);
      end else if (popOk && !capAccept) begin
        entryCount <= entryCount - CNT_W'(1);
      end
      if (capDrop || capReplace) begin
        overflow <= 1'b1;
      end
    end
  end

  assign popIndex = rdPtr;

endmodule

// File: rtl/spi_rx_popq.sv
module spi_rx_popq
  import spi_rx_popq_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 16,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capValid,
  input  logic [DATA_W-1:0] capData,
  input  logic              popRead,
  input  logic              flush,
  input  logic              overwriteMode,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  entryCount,
  output logic [PTR_W-1:0]  popIndex,
  output logic              drainReq,
  output logic              overflow
);

  qStrobes_t strobes;

  rxq_ctrl #(
    .DEPTH(DEPTH),
    .PTR_W(PTR_W),
    .CNT_W(CNT_W)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .capValid     (capValid),
    .popRead      (popRead),
    .flush        (flush),
    .overwriteMode(overwriteMode),
    .strobes      (strobes),
    .entryCount   (entryCount),
    .popIndex     (popIndex),
    .overflow     (overflow)
  );

  rxq_store #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .PTR_W (PTR_W)
  ) uStore (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .capData(capData),
    .popData(popData)
  );

  assign drainReq = (entryCount != '0);

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              capValid,
  input logic              popRead,
  input logic              flush,
  input logic              overwriteMode,
  input logic [DATA_W-1:0] popData,
  input logic [CNT_W-1:0]  entryCount,
  input logic [PTR_W-1:0]  popIndex,
  input logic              drainReq,
  input logic              overflow
);

  localparam logic [CNT_W-1:0] FullCount = CNT_W'(DEPTH);

  // R2, R7: the count never exceeds the queue depth.
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= FullCount);

  // R2: a capture into a non-full queue without a pop raises the count by one.
  a_r2_capture_count: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && !popRead && !flush && entryCount < FullCount)
      |=> entryCount == $past(entryCount) + CNT_W'(1));

  // R6: a pop on an empty queue leaves popData and the count untouched.
  a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (popRead && !capValid && !flush && entryCount == '0)
      |=> ($stable(popData) && entryCount == '0));

  // R9: a flush clears the count, the pointer and the flag.
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (entryCount == '0 && popIndex == '0 && !overflow));

  // R7, R8: a capture while full without a pop always sets overflow.
  a_r7_full_capture_flags: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && !popRead && !flush && entryCount == FullCount) |=> overflow);

  // R8: in overwrite mode the count stays at full.
  a_r8_overwrite_full: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && !popRead && !flush && overwriteMode && entryCount == FullCount)
      |=> entryCount == FullCount);

  // R7: overflow stays set until a flush.
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !flush) |=> overflow);

  // R10: drainReq and the count agree.
  a_r10_drain: assert property (@(posedge clk) disable iff (!rstN)
    drainReq == (entryCount != '0));

endmodule

bind spi_rx_popq rxq_checker #(
  .DEPTH (DEPTH),
  .DATA_W(DATA_W),
  .PTR_W (PTR_W),
  .CNT_W (CNT_W)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .capValid     (capValid),
  .popRead      (popRead),
  .flush        (flush),
  .overwriteMode(overwriteMode),
  .popData      (popData),
  .entryCount   (entryCount),
  .popIndex     (popIndex),
  .drainReq     (drainReq),
  .overflow     (overflow)
);

// File: tb/spi_rx_popq_test.sv
`timescale 1ns/1ps
module spi_rx_popq_test;

  localparam int DEPTH  = 8;
  localparam int DATA_W = 16;
  localparam int PTR_W  = 3;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              capValid;
  logic [DATA_W-1:0] capData;
  logic              popRead;
  logic              flush;
  logic              overwriteMode;
  logic [DATA_W-1:0] popData;
  logic [CNT_W-1:0]  entryCount;
  logic [PTR_W-1:0]  popIndex;
  logic              drainReq;
  logic              overflow;

  int checks = 0;
  int fails  = 0;

  // Reference state built from the requirements.
  logic [DATA_W-1:0] mdlQ[$];
  int                mdlIdx  = 0;
  logic              mdlOvf  = 1'b0;
  logic [DATA_W-1:0] mdlLast = '0;

  always #5 clk = ~clk;

  spi_rx_popq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .capValid(capValid), .capData(capData),
    .popRead(popRead), .flush(flush), .overwriteMode(overwriteMode),
    .popData(popData), .entryCount(entryCount), .popIndex(popIndex),
    .drainReq(drainReq), .overflow(overflow)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, "entryCount", int'(entryCount), mdlQ.size());
    check(tag, "popIndex", int'(popIndex), mdlIdx);
    check(tag, "overflow", int'(overflow), int'(mdlOvf));
    check(tag, "popData", int'(popData), int'(mdlLast));
    check("R10", "drainReq", int'(drainReq), int'(mdlQ.size() != 0));
  endtask

  // Drive one cycle at the falling edge, update the model, sample at the next falling edge.
  task automatic step(input string tag, input logic cap, input logic [DATA_W-1:0] d,
                      input logic pop, input logic fl, input logic ow);
    bit popOk;
    capValid = cap; capData = d; popRead = pop; flush = fl; overwriteMode = ow;
    if (fl) begin
      mdlQ.delete(); mdlIdx = 0; mdlOvf = 1'b0;
    end else begin
      popOk = pop && (mdlQ.size() != 0);
      if (popOk) begin
        mdlLast = mdlQ.pop_front();
        mdlIdx  = (mdlIdx + 1) % DEPTH;
      end
      if (cap) begin
        if (mdlQ.size() == DEPTH) begin
          mdlOvf = 1'b1;
          if (ow) begin
            void'(mdlQ.pop_front());
            mdlQ.push_back(d);
            mdlIdx = (mdlIdx + 1) % DEPTH;
          end
        end else begin
          mdlQ.push_back(d);
        end
      end
    end
    @(negedge clk);
    capValid = 0; popRead = 0; flush = 0;
    checkAll(tag);
  endtask

  task automatic tReset();
    checkAll("R1");
  endtask

  task automatic tOrder();
    for (int i = 0; i < 3; i++) step("R2", 1, 16'hA100 + 16'(i), 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R3", 0, '0, 1, 0, 0);
  endtask

  task automatic tWrap();
    for (int i = 0; i < 11; i++) begin
      step("R2", 1, 16'h5000 + 16'(i), 0, 0, 0);
      step("R4", 0, '0, 1, 0, 0);
    end
  endtask

  task automatic tSimul();
    step("R2", 1, 16'h1111, 0, 0, 0);
    step("R2", 1, 16'h2222, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R5", 1, 16'h3300 + 16'(i), 1, 0, 0);
    step("R3", 0, '0, 1, 0, 0);
    step("R3", 0, '0, 1, 0, 0);
  endtask

  task automatic tEmptyPop();
    step("R6", 0, '0, 1, 0, 0);
    step("R6", 0, '0, 1, 0, 0);
  endtask

  task automatic tDrop();
    for (int i = 0; i < DEPTH; i++) step("R2", 1, 16'hC000 + 16'(i), 0, 0, 0);
    step("R7", 1, 16'hDEAD, 0, 0, 0);
    step("R7", 0, '0, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) step("R7", 0, '0, 1, 0, 0);
    step("R7", 1, 16'h0042, 0, 0, 0);
  endtask

  task automatic tFlush();
    step("R2", 1, 16'h7777, 0, 0, 0);
    step("R9", 1, 16'h8888, 1, 1, 0);
    step("R2", 1, 16'h9999, 0, 0, 0);
    step("R3", 0, '0, 1, 0, 0);
  endtask

  task automatic tOverwrite();
    for (int i = 0; i < DEPTH; i++) step("R2", 1, 16'hE000 + 16'(i), 0, 0, 1);
    step("R8", 1, 16'hF001, 0, 0, 1);
    step("R8", 1, 16'hF002, 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) step("R8", 0, '0, 1, 0, 1);
    step("R9", 0, '0, 0, 1, 0);
  endtask

  initial begin
    rstN = 0; capValid = 0; capData = '0; popRead = 0; flush = 0; overwriteMode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tReset();
    tOrder();
    tWrap();
    tSimul();
    tEmptyPop();
    tDrop();
    tFlush();
    tEmptyPop();
    tOverwrite();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule